// File: doc/BRIEF.md
# NAND Device Command Front-End

This block is the device-side command front end of an 8-bit multiplexed NAND flash. It watches the shared byte bus. It takes one byte on each rising edge of the write-enable strobe while the chip is selected, and uses the two latch-enable pins to decide whether that byte is a command, an address or data. It counts address cycles and steps through the multi-cycle command sequences for read, program, block erase (single and multi-plane) and copy-back. Each completed operation is reported as a one-cycle decoded strobe, together with the assembled row address and the page-register column.

A column pointer selects where a column address lands in the 528-byte page register: the lower half, the upper half or the 16-byte spare area. A pointer set to the upper half returns to the lower half once an operation has completed. During program data input the column advances by one for every byte and wraps around the page. Program, erase and copy-back hold a busy flag for a number of clocks given on an input. While busy, the block accepts only reset and the two status commands. Undefined commands and out-of-place confirms raise a sticky error flag.

The bus pins are sampled on the internal clock. Write-enable must stay low for at least one clock and high for at least one clock.

Top module: `nand_cmd_frontend`

## Requirements
- R1: A byte is taken only on a low-to-high change of `weN` that the clock sees while `ceN` is low. An edge seen while `ceN` is high has no effect. The results of a taken byte (`opValid`/`opCode`, `dataValid`, `colAddr`, `rowAddr`, `busy`, `illegalSeq`) change at the second clock edge after the edge at which `weN` is first sampled high.
- R2: A taken byte is a command when `cle`=1 and `ale`=0, an address when `ale`=1 and `cle`=0, and data when both are 0. With both high the byte is ignored. Data outside program data input is ignored.
- R3: Read: command 00h, 01h or 50h followed by four address bytes completes with `opCode`=1. The first address byte is the column and the next three are row bytes, least significant first, forming `rowAddr`. The column becomes byte+0 after 00h, byte+256 after 01h, and 512 + (byte mod 16) after 50h.
- R4: A pointer set by 01h returns to the lower half after the next completed read, program or copy-back strobe. A pointer set by 50h stays in place for later operations.
- R5: Program: 80h, four address bytes, any number of data bytes, then 10h gives `opCode`=2, or 11h gives `opCode`=3. Each data byte is reported with `dataValid` and `dataCol` equal to the current column, and the column then advances, going from 527 back to 0.
- R6: Erase: 60h and three row bytes followed by D0h gives `opCode`=4. When another 60h with three row bytes comes before the D0h, the code is 5 and `rowAddr` holds the last row.
- R7: Copy-back: a read started with 00h, then 8Ah, four destination address bytes and 10h gives `opCode`=6. The same sequence started with 03h and confirmed with 11h gives `opCode`=7. A confirm that does not match the opening command is illegal.
- R8: Codes 2 to 7 raise `busy` for exactly `busyCycles` clocks, starting with the strobe cycle. A value of 0 counts as 1.
- R9: While `busy` is high, only FFh, 70h and 71h are accepted. Every other command, and every address or data byte, is ignored, and none of them sets `illegalSeq`.
- R10: FFh reports `opCode`=8, drops `busy`, clears `illegalSeq`, puts the pointer on the lower half and abandons any open sequence. 70h gives code 9, 71h gives code 10 and 90h gives code 11. A status command leaves an open sequence intact.
- R11: An undefined command, a confirm (10h, 11h, D0h, 8Ah) without its matching setup, or an address byte outside an address phase sets `illegalSeq` and returns to idle. The flag stays set until FFh or reset.
- R12: After reset `opValid`, `dataValid`, `busy` and `illegalSeq` are 0, and `colAddr` and `rowAddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe; a byte is taken on its rising edge |
| cle | input | 1 | Marks the byte as a command |
| ale | input | 1 | Marks the byte as an address |
| ioIn | input | 8 | Shared command/address/data bus |
| busyCycles | input | 16 | Busy length in clocks for program, erase and copy-back |
| opValid | output | 1 | One-cycle strobe: an operation was decoded |
| opCode | output | 4 | Operation code, valid with `opValid` |
| rowAddr | output | 24 | Assembled row address |
| colAddr | output | 10 | Current page-register column |
| dataValid | output | 1 | One-cycle strobe: a program data byte was taken |
| dataByte | output | 8 | Data byte, valid with `dataValid` |
| dataCol | output | 10 | Column of the data byte |
| busy | output | 1 | Array operation in progress |
| illegalSeq | output | 1 | Sticky error flag for an illegal sequence |

## Verification
A sequencer stuck in the wrong state shows up on the next bus byte. An expected strobe is missing, or `illegalSeq` rises, two clocks after that byte's write edge. A pointer that failed to return, or a column that did not wrap, appears in `colAddr` on the very next address byte or in `dataCol` on the next data byte. A wrong busy window, or a wrong choice of which commands pass while busy, is seen directly as a wrong length of `busy` and as missing or extra strobes for commands issued during it.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  localparam logic [7:0] CMD_PTR_LOW     = 8'h00;
  localparam logic [7:0] CMD_PTR_HIGH    = 8'h01;
  localparam logic [7:0] CMD_CB_READ     = 8'h03;
  localparam logic [7:0] CMD_PROG_CONF   = 8'h10;
  localparam logic [7:0] CMD_PROG_DUMMY  = 8'h11;
  localparam logic [7:0] CMD_PTR_SPARE   = 8'h50;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_STATUS_MP   = 8'h71;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_CB_DEST     = 8'h8A;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_ERASE_CONF  = 8'hD0;
  localparam logic [7:0] CMD_RESET       = 8'hFF;

  typedef enum logic [3:0] {
    OP_NONE        = 4'd0,
    OP_READ        = 4'd1,
    OP_PROG        = 4'd2,
    OP_PROG_DUMMY  = 4'd3,
    OP_ERASE       = 4'd4,
    OP_ERASE_MULTI = 4'd5,
    OP_CB          = 4'd6,
    OP_CB_DUMMY    = 4'd7,
    OP_RESET       = 4'd8,
    OP_STATUS      = 4'd9,
    OP_STATUS_MP   = 4'd10,
    OP_READ_ID     = 4'd11
  } opKind_e;

  typedef enum logic [1:0] {
    PTR_LOW   = 2'd0,
    PTR_HIGH  = 2'd1,
    PTR_SPARE = 2'd2
  } ptr_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ADDR, ST_PG_ADDR, ST_PG_DATA,
    ST_ER_ADDR, ST_ER_WAIT, ST_CB_ADDR, ST_CB_WAIT
  } seqState_e;

  typedef struct packed {
    logic       colLoad;
    logic       rowLoad;
    logic [1:0] rowIdx;
    logic       rowClear;
    logic       dataWrite;
    logic       ptrSet;
    ptr_e       ptrVal;
    logic       ptrRevert;
    logic       busyStart;
    logic       busyClear;
  } feCtl_t;

endpackage

// File: rtl/nand_fe_capture.sv
module nand_fe_capture (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       cle,
  input  logic       ale,
  input  logic [7:0] ioIn,
  output logic       cmdEvt,
  output logic       addrEvt,
  output logic       dataEvt,
  output logic [7:0] evtByte
);
  logic weDly;
  logic weRise;

  // qualified rising edge of the write strobe
  assign weRise = weN & ~weDly & ~ceN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weDly   <= 1'b1;
      cmdEvt  <= 1'b0;
      addrEvt <= 1'b0;
      dataEvt <= 1'b0;
      evtByte <= '0;
    end else begin
      weDly   <= weN;
      cmdEvt  <= weRise & cle & ~ale;
      addrEvt <= weRise & ale & ~cle;
      dataEvt <= weRise & ~cle & ~ale;
      if (weRise) evtByte <= ioIn;
    end
  end

  assert_single_kind_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdEvt, addrEvt, dataEvt}));

  assert_chip_select_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEvt || addrEvt || dataEvt) |-> ($past(ceN) == 1'b0));

endmodule

// File: rtl/nand_fe_ctrl.sv
module nand_fe_ctrl
  import nand_fe_pkg::*;
#(
  parameter int ROW_BYTES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdEvt,
  input  logic       addrEvt,
  input  logic       dataEvt,
  input  logic [7:0] evtByte,
  input  logic       busyIn,
  output feCtl_t     ctl,
  output logic       opValid,
  output logic [3:0] opCode,
  output logic       illegalSeq
);
  localparam int ADDR_CYCLES = ROW_BYTES + 1;
  localparam int CNT_W       = $clog2(ADDR_CYCLES + 1);

  seqState_e        state, nState;
  logic [CNT_W-1:0] addrCnt, nCnt;
  logic             cbCand, nCbCand;
  logic             cbArm, nCbArm;
  logic             cbDummy, nCbDummy;
  logic             multiErase, nMulti;
  logic             nValid, nIll, raiseIll;
  opKind_e          opReg, nOp;
  logic             statusCmd;

  assign statusCmd = (evtByte == CMD_STATUS) || (evtByte == CMD_STATUS_MP);

  always_comb begin
    nState   = state;
    nCnt     = addrCnt;
    nCbCand  = cbCand;
    nCbArm   = cbArm;
    nCbDummy = cbDummy;
    nMulti   = multiErase;
    nValid   = 1'b0;
    nOp      = OP_NONE;
    nIll     = illegalSeq;
    raiseIll = 1'b0;
    ctl      = '0;

    if (cmdEvt) begin
      if (!busyIn || statusCmd || evtByte == CMD_RESET) begin
        if (!statusCmd) nCbArm = 1'b0;
        case (evtByte)
          CMD_RESET: begin
            nState = ST_IDLE;
            nCnt = '0;
            nCbCand = 1'b0;
            nIll = 1'b0;
            ctl.ptrSet = 1'b1;
            ctl.ptrVal = PTR_LOW;
            ctl.busyClear = 1'b1;
            nValid = 1'b1;
            nOp = OP_RESET;
          end
          CMD_STATUS: begin
            nValid = 1'b1;
            nOp = OP_STATUS;
          end
          CMD_STATUS_MP: begin
            nValid = 1'b1;
            nOp = OP_STATUS_MP;
          end
          CMD_READ_ID: begin
            nState = ST_IDLE;
            nValid = 1'b1;
            nOp = OP_READ_ID;
          end
          CMD_PTR_LOW, CMD_PTR_HIGH, CMD_PTR_SPARE, CMD_CB_READ: begin
            nState = ST_RD_ADDR;
            nCnt = '0;
            ctl.rowClear = 1'b1;
            ctl.ptrSet = 1'b1;
            ctl.ptrVal = (evtByte == CMD_PTR_HIGH)  ? PTR_HIGH :
                         (evtByte == CMD_PTR_SPARE) ? PTR_SPARE : PTR_LOW;
            nCbCand = (evtByte == CMD_PTR_LOW) || (evtByte == CMD_CB_READ);
            nCbDummy = (evtByte == CMD_CB_READ);
          end
          CMD_PROG_SETUP: begin
            nState = ST_PG_ADDR;
            nCnt = '0;
            ctl.rowClear = 1'b1;
          end
          CMD_ERASE_SETUP: begin
            nMulti = (state == ST_ER_WAIT);
            nState = ST_ER_ADDR;
            nCnt = '0;
            ctl.rowClear = 1'b1;
          end
          CMD_CB_DEST: begin
            if (state == ST_IDLE && cbArm) begin
              nState = ST_CB_ADDR;
              nCnt = '0;
              ctl.rowClear = 1'b1;
            end else begin
              raiseIll = 1'b1;
            end
          end
          CMD_PROG_CONF, CMD_PROG_DUMMY: begin
            if (state == ST_PG_DATA) begin
              nOp = (evtByte == CMD_PROG_CONF) ? OP_PROG : OP_PROG_DUMMY;
              nValid = 1'b1;
              ctl.busyStart = 1'b1;
              ctl.ptrRevert = 1'b1;
              nState = ST_IDLE;
            end else if (state == ST_CB_WAIT && (cbDummy == (evtByte == CMD_PROG_DUMMY))) begin
              nOp = cbDummy ? OP_CB_DUMMY : OP_CB;
              nValid = 1'b1;
              ctl.busyStart = 1'b1;
              ctl.ptrRevert = 1'b1;
              nState = ST_IDLE;
            end else begin
              raiseIll = 1'b1;
            end
          end
          CMD_ERASE_CONF: begin
            if (state == ST_ER_WAIT) begin
              nOp = multiErase ? OP_ERASE_MULTI : OP_ERASE;
              nValid = 1'b1;
              ctl.busyStart = 1'b1;
              nState = ST_IDLE;
            end else begin
              raiseIll = 1'b1;
            end
          end
          default: raiseIll = 1'b1;
        endcase
      end
    end else if (addrEvt && !busyIn) begin
      case (state)
        ST_RD_ADDR, ST_PG_ADDR, ST_CB_ADDR: begin
          if (addrCnt == '0) begin
            ctl.colLoad = 1'b1;
          end else begin
            ctl.rowLoad = 1'b1;
            ctl.rowIdx = 2'(addrCnt - 1'b1);
          end
          if (addrCnt == CNT_W'(ADDR_CYCLES - 1)) begin
            if (state == ST_RD_ADDR) begin
              nValid = 1'b1;
              nOp = OP_READ;
              ctl.ptrRevert = 1'b1;
              nState = ST_IDLE;
              nCbArm = cbCand;
            end else if (state == ST_PG_ADDR) begin
              nState = ST_PG_DATA;
            end else begin
              nState = ST_CB_WAIT;
            end
          end else begin
            nCnt = addrCnt + 1'b1;
          end
        end
        ST_ER_ADDR: begin
          ctl.rowLoad = 1'b1;
          ctl.rowIdx = 2'(addrCnt);
          if (addrCnt == CNT_W'(ROW_BYTES - 1)) nState = ST_ER_WAIT;
          else nCnt = addrCnt + 1'b1;
        end
        default: raiseIll = 1'b1;
      endcase
    end else if (dataEvt && !busyIn && state == ST_PG_DATA) begin
      ctl.dataWrite = 1'b1;
    end

    if (raiseIll) begin
      nIll   = 1'b1;
      nState = ST_IDLE;
      nCbArm = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      addrCnt    <= '0;
      cbCand     <= 1'b0;
      cbArm      <= 1'b0;
      cbDummy    <= 1'b0;
      multiErase <= 1'b0;
      opValid    <= 1'b0;
      opReg      <= OP_NONE;
      illegalSeq <= 1'b0;
    end else begin
      state      <= nState;
      addrCnt    <= nCnt;
      cbCand     <= nCbCand;
      cbArm      <= nCbArm;
      cbDummy    <= nCbDummy;
      multiErase <= nMulti;
      opValid    <= nValid;
      opReg      <= nOp;
      illegalSeq <= nIll;
    end
  end

  assign opCode = opReg;

  assert_busy_follows_op_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= 4'd2 && opCode <= 4'd7) |-> busyIn);

  assert_busy_filter_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && cmdEvt && !statusCmd && evtByte != CMD_RESET) |=> !opValid);

  assert_illegal_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (illegalSeq && !(cmdEvt && evtByte == CMD_RESET)) |=> illegalSeq);

  assert_reset_cmd_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEvt && evtByte == CMD_RESET) |=> (!illegalSeq && opValid && opCode == 4'd8));

endmodule

// File: rtl/nand_fe_datapath.sv
module nand_fe_datapath
  import nand_fe_pkg::*;
#(
  parameter int ROW_BYTES   = 3,
  parameter int PAGE_BYTES  = 528,
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter int BUSY_W      = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  feCtl_t                        ctl,
  input  logic [7:0]                    evtByte,
  input  logic [BUSY_W-1:0]             busyCycles,
  output logic [$clog2(PAGE_BYTES)-1:0] colAddr,
  output logic [8*ROW_BYTES-1:0]        rowAddr,
  output logic                          dataValid,
  output logic [7:0]                    dataByte,
  output logic [$clog2(PAGE_BYTES)-1:0] dataCol,
  output logic                          busy
);
  localparam int COL_W   = $clog2(PAGE_BYTES);
  localparam int SPARE_W = $clog2(SPARE_BYTES);

  ptr_e              ptr;
  logic [COL_W-1:0]  colLoadVal;
  logic [COL_W-1:0]  colNextVal;
  logic [BUSY_W-1:0] busyCnt;

  always_comb begin
    case (ptr)
      PTR_HIGH:  colLoadVal = COL_W'(HALF_BYTES) + COL_W'(evtByte);
      PTR_SPARE: colLoadVal = COL_W'(2 * HALF_BYTES) + COL_W'(evtByte[SPARE_W-1:0]);
      default:   colLoadVal = COL_W'(evtByte);
    endcase
  end

  assign colNextVal = (colAddr == COL_W'(PAGE_BYTES - 1)) ? '0 : colAddr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= PTR_LOW;
      colAddr   <= '0;
      rowAddr   <= '0;
      dataValid <= 1'b0;
      dataByte  <= '0;
      dataCol   <= '0;
      busyCnt   <= '0;
    end else begin
      if (ctl.ptrSet) ptr <= ctl.ptrVal;
      else if (ctl.ptrRevert && ptr == PTR_HIGH) ptr <= PTR_LOW;

      dataValid <= ctl.dataWrite;
      if (ctl.colLoad) begin
        colAddr <= colLoadVal;
      end else if (ctl.dataWrite) begin
        colAddr  <= colNextVal;
        dataByte <= evtByte;
        dataCol  <= colAddr;
      end

      if (ctl.rowClear) begin
        rowAddr <= '0;
      end else if (ctl.rowLoad) begin
        for (int k = 0; k < ROW_BYTES; k++) begin
          if (int'(ctl.rowIdx) == k) rowAddr[8*k +: 8] <= evtByte;
        end
      end

      if (ctl.busyClear) busyCnt <= '0;
      else if (ctl.busyStart) busyCnt <= (busyCycles == '0) ? BUSY_W'(1) : busyCycles;
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

  assert_col_in_page_R5: assert property (@(posedge clk) disable iff (!rstN)
    colAddr < COL_W'(PAGE_BYTES));

  assert_col_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dataWrite && !ctl.colLoad && colAddr == COL_W'(PAGE_BYTES - 1)) |=> (colAddr == '0));

  assert_ptr_return_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ptrRevert && !ctl.ptrSet && ptr == PTR_HIGH) |=> (ptr == PTR_LOW));

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busyClear |=> !busy);

endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
  import nand_fe_pkg::*;
#(
  parameter int ROW_BYTES   = 3,
  parameter int PAGE_BYTES  = 528,
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter int BUSY_W      = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ceN,
  input  logic                          weN,
  input  logic                          cle,
  input  logic                          ale,
  input  logic [7:0]                    ioIn,
  input  logic [BUSY_W-1:0]             busyCycles,
  output logic                          opValid,
  output logic [3:0]                    opCode,
  output logic [8*ROW_BYTES-1:0]        rowAddr,
  output logic [$clog2(PAGE_BYTES)-1:0] colAddr,
  output logic                          dataValid,
  output logic [7:0]                    dataByte,
  output logic [$clog2(PAGE_BYTES)-1:0] dataCol,
  output logic                          busy,
  output logic                          illegalSeq
);
  logic       cmdEvt, addrEvt, dataEvt;
  logic [7:0] evtByte;
  feCtl_t     ctl;

  nand_fe_capture capture_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .cle(cle), .ale(ale),
    .ioIn(ioIn), .cmdEvt(cmdEvt), .addrEvt(addrEvt), .dataEvt(dataEvt),
    .evtByte(evtByte)
  );

  nand_fe_ctrl #(.ROW_BYTES(ROW_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdEvt(cmdEvt), .addrEvt(addrEvt),
    .dataEvt(dataEvt), .evtByte(evtByte), .busyIn(busy), .ctl(ctl),
    .opValid(opValid), .opCode(opCode), .illegalSeq(illegalSeq)
  );

  nand_fe_datapath #(
    .ROW_BYTES(ROW_BYTES), .PAGE_BYTES(PAGE_BYTES), .HALF_BYTES(HALF_BYTES),
    .SPARE_BYTES(SPARE_BYTES), .BUSY_W(BUSY_W)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .evtByte(evtByte),
    .busyCycles(busyCycles), .colAddr(colAddr), .rowAddr(rowAddr),
    .dataValid(dataValid), .dataByte(dataByte), .dataCol(dataCol), .busy(busy)
  );

endmodule

// File: tb/nand_cmd_frontend_tb.sv
module nand_cmd_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [7:0]  ioIn = '0;
  logic [15:0] busyCycles = 16'd1;
  logic        opValid, dataValid, busy, illegalSeq;
  logic [3:0]  opCode;
  logic [23:0] rowAddr;
  logic [9:0]  colAddr, dataCol;
  logic [7:0]  dataByte;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic        sValid, sDv, sBusy, sIll;
  logic [3:0]  sCode;
  logic [23:0] sRow;
  logic [9:0]  sCol, sDc;
  logic [7:0]  sDb;

  always #4 clk = ~clk;

  nand_cmd_frontend dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .cle(cle), .ale(ale),
    .ioIn(ioIn), .busyCycles(busyCycles), .opValid(opValid), .opCode(opCode),
    .rowAddr(rowAddr), .colAddr(colAddr), .dataValid(dataValid),
    .dataByte(dataByte), .dataCol(dataCol), .busy(busy), .illegalSeq(illegalSeq)
  );

  // kind: 0 command, 1 address, 2 data, 3 cle and ale both high
  task automatic busOp(input int kind, input logic [7:0] b, input logic ceLvl);
    @(negedge clk);
    ceN = ceLvl; cle = (kind == 0 || kind == 3); ale = (kind == 1 || kind == 3);
    ioIn = b; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sValid = opValid; sCode = opCode; sIll = illegalSeq; sDv = dataValid;
    sDb = dataByte; sDc = dataCol; sBusy = busy; sCol = colAddr; sRow = rowAddr;
    ceN = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);  busOp(0, b, 1'b0); endtask
  task automatic addr(input logic [7:0] b); busOp(1, b, 1'b0); endtask
  task automatic dat(input logic [7:0] b);  busOp(2, b, 1'b0); endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  // {kind[1:0], byte[7:0], expCode[3:0], expIll, req[3:0]}
  localparam int NV = 60;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0,8'h00,4'd0,1'b0,4'd3}, {2'd1,8'h10,4'd0,1'b0,4'd3},
    {2'd1,8'h01,4'd0,1'b0,4'd3}, {2'd1,8'h02,4'd0,1'b0,4'd3},
    {2'd1,8'h03,4'd1,1'b0,4'd3}, {2'd0,8'h70,4'd9,1'b0,4'd10},
    {2'd0,8'h80,4'd0,1'b0,4'd5}, {2'd1,8'h00,4'd0,1'b0,4'd5},
    {2'd1,8'h01,4'd0,1'b0,4'd5}, {2'd1,8'h00,4'd0,1'b0,4'd5},
    {2'd1,8'h00,4'd0,1'b0,4'd5}, {2'd2,8'hAA,4'd0,1'b0,4'd5},
    {2'd2,8'hBB,4'd0,1'b0,4'd5}, {2'd0,8'h10,4'd2,1'b0,4'd5},
    {2'd0,8'h60,4'd0,1'b0,4'd6}, {2'd1,8'h01,4'd0,1'b0,4'd6},
    {2'd1,8'h02,4'd0,1'b0,4'd6}, {2'd1,8'h03,4'd0,1'b0,4'd6},
    {2'd0,8'h60,4'd0,1'b0,4'd6}, {2'd1,8'h04,4'd0,1'b0,4'd6},
    {2'd1,8'h05,4'd0,1'b0,4'd6}, {2'd1,8'h06,4'd0,1'b0,4'd6},
    {2'd0,8'hD0,4'd5,1'b0,4'd6}, {2'd0,8'h60,4'd0,1'b0,4'd6},
    {2'd1,8'h07,4'd0,1'b0,4'd6}, {2'd1,8'h08,4'd0,1'b0,4'd6},
    {2'd1,8'h09,4'd0,1'b0,4'd6}, {2'd0,8'h71,4'd10,1'b0,4'd10},
    {2'd0,8'hD0,4'd4,1'b0,4'd6}, {2'd0,8'h90,4'd11,1'b0,4'd10},
    {2'd0,8'h10,4'd0,1'b1,4'd11}, {2'd0,8'hFF,4'd8,1'b0,4'd10},
    {2'd1,8'h00,4'd0,1'b1,4'd11}, {2'd0,8'hFF,4'd8,1'b0,4'd10},
    {2'd0,8'h00,4'd0,1'b0,4'd7}, {2'd1,8'h00,4'd0,1'b0,4'd7},
    {2'd1,8'h01,4'd0,1'b0,4'd7}, {2'd1,8'h00,4'd0,1'b0,4'd7},
    {2'd1,8'h00,4'd1,1'b0,4'd7}, {2'd0,8'h8A,4'd0,1'b0,4'd7},
    {2'd1,8'h00,4'd0,1'b0,4'd7}, {2'd1,8'h02,4'd0,1'b0,4'd7},
    {2'd1,8'h00,4'd0,1'b0,4'd7}, {2'd1,8'h00,4'd0,1'b0,4'd7},
    {2'd0,8'h10,4'd6,1'b0,4'd7}, {2'd0,8'h03,4'd0,1'b0,4'd7},
    {2'd1,8'h00,4'd0,1'b0,4'd7}, {2'd1,8'h05,4'd0,1'b0,4'd7},
    {2'd1,8'h00,4'd0,1'b0,4'd7}, {2'd1,8'h00,4'd1,1'b0,4'd7},
    {2'd0,8'h8A,4'd0,1'b0,4'd7}, {2'd1,8'h00,4'd0,1'b0,4'd7},
    {2'd1,8'h06,4'd0,1'b0,4'd7}, {2'd1,8'h00,4'd0,1'b0,4'd7},
    {2'd1,8'h00,4'd0,1'b0,4'd7}, {2'd0,8'h11,4'd7,1'b0,4'd7},
    {2'd0,8'h8A,4'd0,1'b1,4'd11}, {2'd0,8'hFF,4'd8,1'b0,4'd10},
    {2'd0,8'h33,4'd0,1'b1,4'd11}, {2'd0,8'hFF,4'd8,1'b0,4'd10}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    ceN = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "opValid", opValid, 0);
    chk("R12", "busy", busy, 0);
    chk("R12", "illegalSeq", illegalSeq, 0);
    chk("R12", "dataValid", dataValid, 0);
    chk("R12", "col/row", {colAddr, rowAddr}, 0);

    // table walk, busy held to one clock
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      busOp(int'(v[18:17]), v[16:9], 1'b0);
      checks++;
      if ({sValid, sValid ? sCode : 4'd0, sIll} != {v[8:5] != 4'd0, v[8:5], v[4]}) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual valid %0b code %0d ill %0b expected code %0d ill %0b",
                 v[3:0], i, sValid, sCode, sIll, v[8:5], v[4]);
      end
    end

    // R3 upper-half pointer and row assembly
    cmd(8'h01); addr(8'h05); addr(8'h12); addr(8'h34); addr(8'h56);
    chk("R3", "read code", sValid ? sCode : 0, 1);
    chk("R3", "upper col", sCol, 261);
    chk("R3", "row", sRow, 24'h563412);
    // R4 pointer returned to lower half
    cmd(8'h80); addr(8'h03); addr(8'h00); addr(8'h00); addr(8'h00);
    chk("R4", "col after return", sCol, 3);
    cmd(8'h11);
    chk("R5", "dummy program code", sValid ? sCode : 0, 3);
    waitIdle();

    // R3 spare pointer, R4 persistence, R5 wrap
    cmd(8'h50); addr(8'h1F); addr(8'h01); addr(8'h00); addr(8'h00);
    chk("R3", "spare col", sCol, 527);
    cmd(8'h80); addr(8'h0E); addr(8'h00); addr(8'h00); addr(8'h00);
    chk("R4", "spare kept", sCol, 526);
    dat(8'h11);
    chk("R5", "data col 526", {sDv, sDc, sDb}, {1'b1, 10'd526, 8'h11});
    dat(8'h22);
    chk("R5", "data col 527", {sDv, sDc}, {1'b1, 10'd527});
    dat(8'h33);
    chk("R5", "data col wrap", {sDv, sDc, sDb}, {1'b1, 10'd0, 8'h33});
    chk("R5", "next col", sCol, 1);
    cmd(8'h10);
    chk("R5", "program code", sValid ? sCode : 0, 2);
    waitIdle();
    cmd(8'hFF);

    // R6 erase row
    cmd(8'h60); addr(8'h0A); addr(8'h0B); addr(8'h0C); cmd(8'hD0);
    chk("R6", "erase code", sValid ? sCode : 0, 4);
    chk("R6", "erase row", sRow, 24'h0C0B0A);
    waitIdle();

    // R7 copy-back destination and mismatched confirm
    cmd(8'h00); addr(8'h00); addr(8'h01); addr(8'h02); addr(8'h03);
    cmd(8'h8A); addr(8'h07); addr(8'h21); addr(8'h43); addr(8'h65);
    cmd(8'h10);
    chk("R7", "copy-back code", sValid ? sCode : 0, 6);
    chk("R7", "dest row/col", {sRow, sCol}, {24'h654321, 10'd7});
    waitIdle();
    cmd(8'h03); addr(8'h00); addr(8'h00); addr(8'h00); addr(8'h00);
    cmd(8'h8A); addr(8'h00); addr(8'h00); addr(8'h00); addr(8'h00);
    cmd(8'h10);
    chk("R7", "mismatch flagged", {sValid, sIll}, {1'b0, 1'b1});
    cmd(8'hFF);

    // R8 busy length
    busyCycles = 16'd5;
    cmd(8'h80); addr(8'h00); addr(8'h00); addr(8'h00); addr(8'h00); cmd(8'h10);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R8", "busy clocks", n, 5);
    busyCycles = 16'd0;
    cmd(8'h80); addr(8'h00); addr(8'h00); addr(8'h00); addr(8'h00); cmd(8'h10);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R8", "busy zero as one", n, 1);

    // R9 filtering while busy
    busyCycles = 16'd60;
    cmd(8'h80); addr(8'h00); addr(8'h00); addr(8'h00); addr(8'h00); cmd(8'h10);
    cmd(8'h90);
    chk("R9", "read id ignored", {sValid, sBusy}, {1'b0, 1'b1});
    cmd(8'h70);
    chk("R9", "status accepted", {sValid, sCode, sBusy}, {1'b1, 4'd9, 1'b1});
    cmd(8'h80);
    addr(8'h00);
    chk("R9", "addr ignored", {sIll, sBusy}, {1'b0, 1'b1});
    waitIdle();
    addr(8'h00);
    chk("R9", "setup was ignored", sIll, 1);
    cmd(8'hFF);

    // R10 reset during busy
    cmd(8'h80); addr(8'h00); addr(8'h00); addr(8'h00); addr(8'h00); cmd(8'h10);
    cmd(8'hFF);
    chk("R10", "reset drops busy", {sValid, sCode, sBusy, sIll}, {1'b1, 4'd8, 1'b0, 1'b0});
    busyCycles = 16'd1;
    cmd(8'h01); cmd(8'hFF);
    cmd(8'h80); addr(8'h04);
    chk("R10", "reset restores lower half", sCol, 4);
    cmd(8'hFF);

    // R1 chip select gating
    cmd(8'h33);
    busOp(0, 8'hFF, 1'b1);
    chk("R1", "deselected reset ignored", {sValid, sIll}, {1'b0, 1'b1});
    cmd(8'hFF);
    chk("R1", "selected reset taken", {sValid, sIll}, {1'b1, 1'b0});

    // R2 both latches high, stray data
    busOp(3, 8'h80, 1'b0);
    chk("R2", "both high ignored", {sValid, sIll}, {1'b0, 1'b0});
    addr(8'h00);
    chk("R2", "no program opened", sIll, 1);
    cmd(8'hFF);
    dat(8'h55);
    chk("R2", "idle data ignored", {sDv, sIll}, {1'b0, 1'b0});

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule